// File: doc/BRIEF.md
# Lane-Configurable Packed Adder

This block adds two 64-bit operands as a row of independent lanes. A run-time select sets the lane width to 8, 16 or 32 bits, and a second select sets how each lane treats overflow: plain wraparound, clamping to the signed range, or clamping to the unsigned range. No carry crosses from one lane into the next. The result is held in a register and appears one clock after the operands are presented, with a valid flag.

The datapath is a chain of byte slices. Each slice's carry input is either cut or taken from the slice below, depending on the chosen lane width. A per-byte clamp stage then replaces the raw sum when the lane's top slice reports overflow. Unsigned or signed clamping of 32-bit lanes is not supported. When that combination is requested, the block raises an error flag for that result and returns the wraparound sum.

Top module: `pkd_packed_add`

## Requirements
- R1: While reset is asserted, and right after it is released, `vld_o`, `cfg_err_o` and `sum_o` are all zero.
- R2: `vld_o` equals `vld_i` from the previous clock. `sum_o` takes a new value only in the cycle after `vld_i` was high, and holds its value otherwise.
- R3: Lane width encoding on `lane_sz_i` is 0 = 8-bit lanes, 1 = 16-bit lanes, 2 = 32-bit lanes, and 3 = 32-bit lanes. In wraparound mode each lane returns the low bits of its own sum, and no carry enters the next lane.
- R4: In signed mode with 8-bit lanes, a byte sum below -128 gives 80h and a byte sum above 127 gives 7Fh. Any other byte sum is returned unchanged.
- R5: In signed mode with 16-bit lanes, each word sum is clamped to the range 8000h..7FFFh.
- R6: In unsigned mode with 8- or 16-bit lanes, a lane sum above the lane maximum gives all ones. Any other lane sum is returned unchanged, so a lane result is never below that lane's `dst_i` value.
- R7: Mode encoding on `mode_i` is 0 = wraparound, 1 = signed clamp, 2 = unsigned clamp, and 3 = wraparound.
- R8: Requesting mode 1 or mode 2 with 32-bit lanes (`lane_sz_i` 2 or 3) sets `cfg_err_o` for that result, and `sum_o` carries the wraparound sum.
- R9: `cfg_err_o` is high only in a cycle where `vld_o` is high, and only for a result whose request was the illegal combination of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operands and selects are valid this cycle |
| lane_sz_i | input | 2 | Lane width select (see R3) |
| mode_i | input | 2 | Overflow behaviour select (see R7) |
| dst_i | input | 64 | First addend |
| src_i | input | 64 | Second addend |
| vld_o | output | 1 | Registered result is new this cycle |
| sum_o | output | 64 | Registered packed sum |
| cfg_err_o | output | 1 | Result came from an unsupported width/mode pair |

## Verification
The bench first targets carry leakage across lane boundaries: it adds all-ones to one in every lane at each width. A wrongly gated carry chain would then leave a 1 in the next lane instead of zeros. It then drives sums just past both signed limits and just past the unsigned limit, at both byte and word width. A clamp that took its direction from the wrong operand, or from the wrong top slice, would return the opposite bound or a wrapped value. The illegal width/mode pairs and the reserved encodings are applied to show that the error flag rises only for the two forbidden modes at 32-bit width. A seeded sweep over every width and mode, together with idle cycles that change the inputs, catches results that change without a valid strobe.

// File: rtl/pkd_pkg.sv
package pkd_pkg;

   typedef enum logic [1:0] {
      LSZ_B8   = 2'd0,
      LSZ_W16  = 2'd1,
      LSZ_D32  = 2'd2,
      LSZ_D32X = 2'd3
   } lane_sz_e;

   typedef enum logic [1:0] {
      OVF_WRAP = 2'd0,
      OVF_SSAT = 2'd1,
      OVF_USAT = 2'd2,
      OVF_RSVD = 2'd3
   } ovf_mode_e;

   localparam int unsigned SLICE_W = 8;

endpackage

// File: rtl/pkd_byte_slice.sv
module pkd_byte_slice
   import pkd_pkg::*;
(
   input  logic [SLICE_W-1:0] a_i,
   input  logic [SLICE_W-1:0] b_i,
   input  logic               cin_i,
   output logic [SLICE_W-1:0] s_o,
   output logic               cout_o,
   output logic               cmsb_o
);
   localparam int unsigned MSB = SLICE_W - 1;

   logic [MSB:0] low_sum;

   always_comb begin
      low_sum = {1'b0, a_i[MSB-1:0]} + {1'b0, b_i[MSB-1:0]} + {{MSB{1'b0}}, cin_i};
      cmsb_o  = low_sum[MSB];
      s_o     = {a_i[MSB] ^ b_i[MSB] ^ low_sum[MSB], low_sum[MSB-1:0]};
      cout_o  = (a_i[MSB] & b_i[MSB]) | (a_i[MSB] & low_sum[MSB]) | (b_i[MSB] & low_sum[MSB]);
   end
endmodule

// File: rtl/pkd_lane_clamp.sv
module pkd_lane_clamp
   import pkd_pkg::*;
(
   input  logic [SLICE_W-1:0] raw_i,
   input  logic               sat_s_i,
   input  logic               sat_u_i,
   input  logic               top_ovs_i,
   input  logic               top_cout_i,
   input  logic               top_neg_i,
   input  logic               is_top_i,
   output logic [SLICE_W-1:0] q_o
);
   always_comb begin
      if (sat_u_i && top_cout_i) begin
         q_o = '1;
      end else if (sat_s_i && top_ovs_i) begin
         if (is_top_i) q_o = top_neg_i ? {1'b1, {(SLICE_W-1){1'b0}}} : {1'b0, {(SLICE_W-1){1'b1}}};
         else          q_o = top_neg_i ? '0 : '1;
      end else begin
         q_o = raw_i;
      end
   end
endmodule

// File: rtl/pkd_packed_add.sv
module pkd_packed_add
   import pkd_pkg::*;
#(
   parameter int unsigned NUM_BYTES = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vld_i,
   input  logic [1:0]               lane_sz_i,
   input  logic [1:0]               mode_i,
   input  logic [NUM_BYTES*8-1:0]   dst_i,
   input  logic [NUM_BYTES*8-1:0]   src_i,
   output logic                     vld_o,
   output logic [NUM_BYTES*8-1:0]   sum_o,
   output logic                     cfg_err_o
);
   localparam int unsigned DATA_W = NUM_BYTES * SLICE_W;

   if (NUM_BYTES % 4 != 0 || NUM_BYTES == 0) begin : g_bad_width
      $error("pkd_packed_add: NUM_BYTES must be a nonzero multiple of 4");
   end

   logic sz8, sz16, sz32;
   logic sat_s, sat_u, illegal;

   always_comb begin
      sz8     = (lane_sz_i == LSZ_B8);
      sz16    = (lane_sz_i == LSZ_W16);
      sz32    = lane_sz_i[1];
      illegal = sz32 && ((mode_i == OVF_SSAT) || (mode_i == OVF_USAT));
      sat_s   = (mode_i == OVF_SSAT) && !sz32;
      sat_u   = (mode_i == OVF_USAT) && !sz32;
   end

   logic [NUM_BYTES-1:0] cin, cout, cmsb, ovs;
   logic [DATA_W-1:0]    raw, clamped;

   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_slice
      localparam bit   AT_W16 = (i % 2) == 0;
      localparam bit   AT_D32 = (i % 4) == 0;
      localparam int   T16    = i | 1;
      localparam int   T32    = i | 3;

      if (i == 0) begin : g_first
         assign cin[i] = 1'b0;
      end else begin : g_link
         logic cut;
         assign cut    = sz8 | (sz16 & AT_W16) | AT_D32;
         assign cin[i] = cut ? 1'b0 : cout[i-1];
      end

      pkd_byte_slice u_slice (
         .a_i    (dst_i[i*SLICE_W +: SLICE_W]),
         .b_i    (src_i[i*SLICE_W +: SLICE_W]),
         .cin_i  (cin[i]),
         .s_o    (raw[i*SLICE_W +: SLICE_W]),
         .cout_o (cout[i]),
         .cmsb_o (cmsb[i])
      );

      assign ovs[i] = cmsb[i] ^ cout[i];

      logic t_ovs, t_cout, t_neg, t_top;
      always_comb begin
         if (sz8) begin
            t_ovs  = ovs[i];
            t_cout = cout[i];
            t_neg  = dst_i[i*SLICE_W + SLICE_W-1];
            t_top  = 1'b1;
         end else if (sz16) begin
            t_ovs  = ovs[T16];
            t_cout = cout[T16];
            t_neg  = dst_i[T16*SLICE_W + SLICE_W-1];
            t_top  = (i == T16);
         end else begin
            t_ovs  = ovs[T32];
            t_cout = cout[T32];
            t_neg  = dst_i[T32*SLICE_W + SLICE_W-1];
            t_top  = (i == T32);
         end
      end

      pkd_lane_clamp u_clamp (
         .raw_i      (raw[i*SLICE_W +: SLICE_W]),
         .sat_s_i    (sat_s),
         .sat_u_i    (sat_u),
         .top_ovs_i  (t_ovs),
         .top_cout_i (t_cout),
         .top_neg_i  (t_neg),
         .is_top_i   (t_top),
         .q_o        (clamped[i*SLICE_W +: SLICE_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o     <= 1'b0;
         cfg_err_o <= 1'b0;
         sum_o     <= '0;
      end else begin
         vld_o     <= vld_i;
         cfg_err_o <= vld_i & illegal;
         if (vld_i) sum_o <= clamped;
      end
   end
endmodule

// File: rtl/pkd_packed_add_chk.sv
module pkd_packed_add_chk #(
   parameter int unsigned NUM_BYTES = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   vld_i,
   input logic [1:0]             lane_sz_i,
   input logic [1:0]             mode_i,
   input logic [NUM_BYTES*8-1:0] dst_i,
   input logic [NUM_BYTES*8-1:0] src_i,
   input logic                   vld_o,
   input logic [NUM_BYTES*8-1:0] sum_o,
   input logic                   cfg_err_o
);
   logic bad_pair;
   assign bad_pair = lane_sz_i[1] && (mode_i == 2'd1 || mode_i == 2'd2);

   // R2
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) vld_i |=> vld_o);
   // R2
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !vld_i |=> !vld_o);
   // R2
   sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !vld_i |=> $stable(sum_o));
   // R8
   cfg_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) (vld_i && bad_pair) |=> cfg_err_o);
   // R9
   cfg_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !(vld_i && bad_pair) |=> !cfg_err_o);
   // R9
   cfg_err_vld_chk: assert property (@(posedge clk) disable iff (!rst_n) cfg_err_o |-> vld_o);
   // R6
   usat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && lane_sz_i == 2'd0 && mode_i == 2'd2) |=> sum_o[7:0] >= $past(dst_i[7:0]));
   // R3
   wrap_byte0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && lane_sz_i == 2'd0 && mode_i == 2'd0) |=> sum_o[7:0] == 8'($past(dst_i[7:0]) + $past(src_i[7:0])));
endmodule

bind pkd_packed_add pkd_packed_add_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vld_i     (vld_i),
   .lane_sz_i (lane_sz_i),
   .mode_i    (mode_i),
   .dst_i     (dst_i),
   .src_i     (src_i),
   .vld_o     (vld_o),
   .sum_o     (sum_o),
   .cfg_err_o (cfg_err_o)
);

// File: tb/pkd_packed_add_bench.sv
`timescale 1ns/1ps
module pkd_packed_add_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld_i = 1'b0;
   logic [1:0]  lane_sz_i = '0;
   logic [1:0]  mode_i = '0;
   logic [63:0] dst_i = '0;
   logic [63:0] src_i = '0;
   logic        vld_o;
   logic [63:0] sum_o;
   logic        cfg_err_o;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   pkd_packed_add #(.NUM_BYTES(8)) u_pkd_packed_add (
      .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .lane_sz_i(lane_sz_i), .mode_i(mode_i),
      .dst_i(dst_i), .src_i(src_i), .vld_o(vld_o), .sum_o(sum_o), .cfg_err_o(cfg_err_o)
   );

   function automatic logic [63:0] ref_add(logic [63:0] a, logic [63:0] b, logic [1:0] z, logic [1:0] m);
      int w, md;
      longint ua, ub, sa, sb, s, mask, hi, lo;
      logic [63:0] r;
      w  = (z == 2'd0) ? 8 : (z == 2'd1) ? 16 : 32;
      md = int'(m);
      if (md == 3 || w == 32) md = 0;
      mask = (longint'(1) << w) - 1;
      r = '0;
      for (int k = 0; k < 64 / w; k++) begin
         ua = longint'(a >> (k * w)) & mask;
         ub = longint'(b >> (k * w)) & mask;
         s  = ua + ub;
         if (md == 2 && s > mask) s = mask;
         if (md == 1) begin
            hi = mask >> 1;
            lo = -(hi + 1);
            sa = (ua > hi) ? ua - (mask + 1) : ua;
            sb = (ub > hi) ? ub - (mask + 1) : ub;
            s  = sa + sb;
            if (s > hi) s = hi;
            if (s < lo) s = lo;
         end
         r = r | (64'(s & mask) << (k * w));
      end
      return r;
   endfunction

   function automatic logic ref_err(logic [1:0] z, logic [1:0] m);
      return z[1] && (m == 2'd1 || m == 2'd2);
   endfunction

   task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk1(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic apply(input logic [63:0] d, input logic [63:0] s, input logic [1:0] z,
                        input logic [1:0] m, output logic [63:0] q, output logic e);
      @(negedge clk);
      dst_i = d; src_i = s; lane_sz_i = z; mode_i = m; vld_i = 1'b1;
      @(negedge clk);
      vld_i = 1'b0;
      chk1("R2 vld_o after strobe", vld_o, 1'b1);
      q = sum_o;
      e = cfg_err_o;
   endtask

   task automatic t_reset();
      chk1("R1 vld_o in reset", vld_o, 1'b0);
      chk1("R1 cfg_err_o in reset", cfg_err_o, 1'b0);
      chk64("R1 sum_o in reset", sum_o, 64'h0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk1("R1 vld_o after release", vld_o, 1'b0);
      chk64("R1 sum_o after release", sum_o, 64'h0);
   endtask

   task automatic t_wrap();
      logic [63:0] q; logic e;
      // R3 byte lanes: 53+EC=3F, FC+14=10
      apply(64'h0000_0000_0000_FC53, 64'h0000_0000_0000_14EC, 2'd0, 2'd0, q, e);
      chk64("R3 byte wrap", q, 64'h0000_0000_0000_103F);
      // R3 dword lanes
      apply(64'h0123_4567_FFF0_5C43, 64'h8000_0000_000F_A3BE, 2'd2, 2'd0, q, e);
      chk64("R3 dword wrap", q, 64'h8123_4567_0000_0001);
      chk1("R9 no err for wrap", e, 1'b0);
      // R3 no carry across word lanes
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 2'd1, 2'd0, q, e);
      chk64("R3 word lanes isolated", q, 64'h0);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd0, 2'd0, q, e);
      chk64("R3 byte lanes isolated", q, 64'h0);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd3, 2'd0, q, e);
      chk64("R3 size 3 acts as 32-bit", q, 64'h0);
      // R7 mode 3 wraps
      apply(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0002, 2'd0, 2'd3, q, e);
      chk64("R7 reserved mode wraps", q, 64'h0000_0000_0000_0001);
   endtask

   task automatic t_ssat_byte();
      logic [63:0] q; logic e;
      apply(64'h007F_809A_0770_77D2, 64'h0001_FFA8_F744_1488, 2'd0, 2'd1, q, e);
      chk64("R4 signed byte clamp", q, 64'h007F_8080_FE7F_7F80);
      chk1("R9 no err signed byte", e, 1'b0);
   endtask

   task automatic t_ssat_word();
      logic [63:0] q; logic e;
      apply(64'h7FFF_8000_1234_FFFF, 64'h0001_FFFF_1111_0001, 2'd1, 2'd1, q, e);
      chk64("R5 signed word clamp", q, 64'h7FFF_8000_2345_0000);
   endtask

   task automatic t_usat();
      logic [63:0] q; logic e;
      apply(64'hFF80_1000_FE7F_01C0, 64'h0180_2000_017F_FE3F, 2'd0, 2'd2, q, e);
      chk64("R6 unsigned byte clamp", q, 64'hFFFF_3000_FFFE_FFFF);
      apply(64'hFFFF_8000_1234_F000, 64'h0001_7FFF_0001_1000, 2'd1, 2'd2, q, e);
      chk64("R6 unsigned word clamp", q, 64'hFFFF_FFFF_1235_FFFF);
   endtask

   task automatic t_illegal();
      logic [63:0] q; logic e;
      apply(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 2'd1, q, e);
      chk1("R8 err signed 32", e, 1'b1);
      chk64("R8 wrap on signed 32", q, 64'h8000_0000_0000_0000);
      apply(64'hFFFF_FFFF_0000_0005, 64'h0000_0001_0000_0003, 2'd3, 2'd2, q, e);
      chk1("R8 err unsigned 32", e, 1'b1);
      chk64("R8 wrap on unsigned 32", q, 64'h0000_0000_0000_0008);
      apply(64'h1, 64'h1, 2'd2, 2'd3, q, e);
      chk1("R9 no err reserved mode 32", e, 1'b0);
      @(negedge clk);
      chk1("R9 err clears when idle", cfg_err_o, 1'b0);
   endtask

   task automatic t_hold();
      logic [63:0] q; logic e;
      apply(64'h1111_2222_3333_4444, 64'h0101_0101_0101_0101, 2'd0, 2'd0, q, e);
      dst_i = 64'hDEAD_BEEF_DEAD_BEEF; src_i = 64'h1234_5678_9ABC_DEF0; mode_i = 2'd1;
      repeat (3) @(negedge clk);
      chk1("R2 vld_o low when idle", vld_o, 1'b0);
      chk64("R2 sum held when idle", sum_o, 64'h1212_2323_3434_4545);
   endtask

   task automatic t_sweep();
      logic [63:0] st, a, b, q;
      logic e;
      st = 64'h9E37_79B9_7F4A_7C15;
      for (int n = 0; n < 192; n++) begin
         st = st ^ (st << 13); st = st ^ (st >> 7); st = st ^ (st << 17);
         a  = st;
         st = st ^ (st << 13); st = st ^ (st >> 7); st = st ^ (st << 17);
         b  = st;
         apply(a, b, 2'(n % 4), 2'((n / 4) % 4), q, e);
         chk64("R3 R4 R5 R6 R7 sweep sum", q, ref_add(a, b, 2'(n % 4), 2'((n / 4) % 4)));
         chk1("R8 sweep err", e, ref_err(2'(n % 4), 2'((n / 4) % 4)));
      end
   endtask

   initial begin
      #(100000 * 5);
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_wrap();
      t_ssat_byte();
      t_ssat_word();
      t_usat();
      t_illegal();
      t_hold();
      t_sweep();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule